// File: doc/BRIEF.md
# Cascadable 8/16-bit pulse generator pair

The block holds two down-counters that produce a PWM-style waveform on one output pin. Each counter alternates between a low-phase reload value and a high-phase reload value. On every underflow it toggles its level and takes the other reload value, so one full period lasts (low+1)+(high+1) counted ticks. A mode field sets how the two counters work together:
- as two independent 8-bit channels;
- as an 8-bit prescaler whose underflows clock the upper channel;
- as one 16-bit counter built from both bytes.

The upper channel always drives the pin.

Software reaches the block through a small byte-wide register port. The port holds four reload bytes and one control/status byte. The control/status byte carries run, mode, pin enable, interrupt enable and a sticky underflow flag. When the pin enable is clear, the pin carries a general-purpose port value instead of the pulse. The interrupt request is active while the flag and the interrupt enable are both set.

Top module: `pgen_pair`

## Requirements
- R1: After reset, the control byte reads 0x00, every reload byte reads 0x00, `irq_o` is 0 and `pin_o` follows `gpio_i`.
- R2: Register map. Address 0 is lower-channel low width and address 1 is lower-channel high width. Address 2 is upper-channel low width and address 3 is upper-channel high width. Address 4 is control, with bit0 run, bits2:1 mode, bit3 pin enable, bit4 interrupt enable and bit5 underflow flag. Every reload byte reads back the value last written to it.
- R3: Mode 00 (dual). The upper channel counts one step per tick. The pin is low for (upper low width + 1) ticks, then high for (upper high width + 1) ticks.
- R4: Mode 01 (prescaler). The upper channel steps only on underflows of the lower channel. With lower reloads both set to 1, the low and high phases on the pin are twice (width+1) ticks long.
- R5: Mode 10 (cascade). The pin phases are (W+1) ticks long. W is the 16-bit value with the upper-channel byte as its high byte and the lower-channel byte as its low byte. The upper byte decrements only when the lower byte wraps.
- R6: The counters advance only in cycles where `cnt_en_i` is 1 and run is set. While `cnt_en_i` is 0, the pin level and the flag hold.
- R7: The underflow flag is set by an upper-channel underflow from 00h to FFh in the 8-bit modes. In mode 10 it is set by a combined underflow from 0000h to FFFFh.
- R8: Writing 0 to flag bit5 clears the flag. Writing 1 to it leaves the flag unchanged.
- R9: When a hardware set of the flag and a software clear fall in the same cycle, the flag ends up set.
- R10: A read of the control byte with `reg_rmw_i` high returns 1 in bit5. A plain read returns the true flag.
- R11: `irq_o` is 1 exactly when both the interrupt enable and the flag are 1.
- R12: With pin enable 0, `pin_o` equals `gpio_i`. With pin enable 1, `pin_o` carries the pulse level.
- R13: While run is 0, both counters are held at their low-width reload and the pulse level is 0. A restart therefore begins with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count tick from the prescaler clock source |
| reg_we_i | input | 1 | Register write strobe |
| reg_rmw_i | input | 1 | Marks the current read as part of a read-modify-write |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on the address |
| gpio_i | input | 1 | General-purpose port value used when the pulse is disabled |
| pin_o | output | 1 | Output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- each register access lasts one cycle;
- a control write carries a whole byte;
- the flag can only be raised by a running counter.

They also treat the mode field as stable while run is set. The stimulus drives every input on the falling clock edge. It changes the mode or the reload values only after a write that clears run. To separate the prescaler and cascade orderings from plain counting, it uses reload values whose phase lengths differ between modes.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int NCH = 2;
  localparam int AW  = 3;
  localparam logic [AW-1:0] CTRL_ADDR = 3'd4;

  typedef enum logic [1:0] {
    MODE_DUAL  = 2'b00,
    MODE_PRESC = 2'b01,
    MODE_CASC  = 2'b10
  } mode_e;

  localparam int B_RUN = 0;
  localparam int B_OE  = 3;
  localparam int B_IE  = 4;
  localparam int B_UF  = 5;
endpackage

// File: rtl/pgen_cnt.sv
module pgen_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgen_regs.sv
module pgen_regs import pgen_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          rmw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          uf_set_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] rld_lo_o [NCH],
  output logic [DW-1:0] rld_hi_o [NCH],
  output logic          run_o,
  output mode_e         mode_o,
  output logic          oe_o,
  output logic          ie_o,
  output logic          uf_o
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == CTRL_ADDR);

  for (genvar k = 0; k < NCH; k++) begin : g_rld
    localparam logic [AW-1:0] LO_ADDR = AW'(2 * k);
    localparam logic [AW-1:0] HI_ADDR = AW'(2 * k + 1);
    logic [DW-1:0] lo_q, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we_i) begin
        if (addr_i == LO_ADDR) lo_q <= wdata_i;
        if (addr_i == HI_ADDR) hi_q <= wdata_i;
      end
    end
    assign rld_lo_o[k] = lo_q;
    assign rld_hi_o[k] = hi_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      mode_o <= MODE_DUAL;
      oe_o   <= 1'b0;
      ie_o   <= 1'b0;
    end else if (ctrl_wr) begin
      run_o  <= wdata_i[B_RUN];
      mode_o <= mode_e'(wdata_i[2:1]);
      oe_o   <= wdata_i[B_OE];
      ie_o   <= wdata_i[B_IE];
    end
  end

  // hardware set beats software clear; writing 1 is ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          uf_o <= 1'b0;
    else if (uf_set_i)                    uf_o <= 1'b1;
    else if (ctrl_wr && !wdata_i[B_UF])   uf_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o[B_RUN] = run_o;
      rdata_o[2:1]   = mode_o;
      rdata_o[B_OE]  = oe_o;
      rdata_o[B_IE]  = ie_o;
      rdata_o[B_UF]  = uf_o | rmw_i;
    end else if (addr_i < CTRL_ADDR) begin
      rdata_o = addr_i[0] ? rld_hi_o[addr_i[1]] : rld_lo_o[addr_i[1]];
    end
  end
endmodule

// File: rtl/pgen_pair.sv
module pgen_pair import pgen_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  logic          reg_we_i,
  input  logic          reg_rmw_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          gpio_i,
  output logic          pin_o,
  output logic          irq_o
);
  logic [DW-1:0] rld_lo [NCH];
  logic [DW-1:0] rld_hi [NCH];
  logic          run_q, oe_q, ie_q, uf_q, uf_set;
  mode_e         mode_q;
  logic          tick;
  logic          dec  [NCH];
  logic          uf   [NCH];
  logic          zero [NCH];
  logic          lvl_q [NCH];

  pgen_regs #(.DW(DW)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .rmw_i    (reg_rmw_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .uf_set_i (uf_set),
    .rdata_o  (reg_rdata_o),
    .rld_lo_o (rld_lo),
    .rld_hi_o (rld_hi),
    .run_o    (run_q),
    .mode_o   (mode_q),
    .oe_o     (oe_q),
    .ie_o     (ie_q),
    .uf_o     (uf_q)
  );

  assign tick = run_q & cnt_en_i;

  always_comb begin
    unique case (mode_q)
      MODE_PRESC: begin
        dec[0] = tick;
        uf[0]  = tick & zero[0];
        dec[1] = uf[0];
        uf[1]  = uf[0] & zero[1];
      end
      MODE_CASC: begin
        // upper byte steps only when lower byte wraps
        dec[0] = tick;
        dec[1] = tick & zero[0];
        uf[0]  = tick & zero[0] & zero[1];
        uf[1]  = uf[0];
      end
      default: begin
        dec[0] = tick;
        dec[1] = tick;
        uf[0]  = tick & zero[0];
        uf[1]  = tick & zero[1];
      end
    endcase
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic          sel_hi, load;
    logic [DW-1:0] ld_val;

    // in cascade both bytes follow the upper channel's phase
    assign sel_hi = (mode_q == MODE_CASC) ? ~lvl_q[NCH-1] : ~lvl_q[k];
    assign load   = ~run_q | uf[k];
    assign ld_val = (run_q & sel_hi) ? rld_hi[k] : rld_lo[k];

    pgen_cnt #(.W(DW)) i_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .dec_i      (dec[k]),
      .load_val_i (ld_val),
      .zero_o     (zero[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lvl_q[k] <= 1'b0;
      else if (!run_q) lvl_q[k] <= 1'b0;
      else if (uf[k])  lvl_q[k] <= ~lvl_q[k];
    end
  end

  assign uf_set = uf[NCH-1];
  assign pin_o  = oe_q ? lvl_q[NCH-1] : gpio_i;
  assign irq_o  = ie_q & uf_q;
endmodule

// File: rtl/pgen_pair_chk.sv
module pgen_pair_chk import pgen_pkg::*; #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          run_i,
  input logic          oe_i,
  input logic          ie_i,
  input logic          uf_i,
  input logic          uf_set_i,
  input logic          pin_o,
  input logic          irq_o
);
  logic clr_wr;
  assign clr_wr = we_i && (addr_i == CTRL_ADDR) && !wdata_i[B_UF];

  AST_UF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i && !clr_wr |=> uf_i);  // R8
  AST_UF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !uf_set_i |=> !uf_i);  // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_set_i |=> uf_i);  // R9
  AST_UF_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uf_i) |-> $past(run_i));  // R7
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!oe_i || !pin_o));  // R13
  AST_NO_IRQ_WITHOUT_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !irq_o);  // R11
endmodule

bind pgen_pair pgen_pair_chk #(.DW(DW)) i_pgen_pair_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .run_i    (run_q),
  .oe_i     (oe_q),
  .ie_i     (ie_q),
  .uf_i     (uf_q),
  .uf_set_i (uf_set),
  .pin_o    (pin_o),
  .irq_o    (irq_o)
);

// File: tb/test_pgen_pair.sv
`timescale 1ns/1ps
module test_pgen_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b1;
  logic       we = 1'b0;
  logic       rmw = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gpio = 1'b0;
  logic       pin, irq;
  int         checks = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  pgen_pair i_pgen_pair (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cnt_en_i    (cnt_en),
    .reg_we_i    (we),
    .reg_rmw_i   (rmw),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .gpio_i      (gpio),
    .pin_o       (pin),
    .irq_o       (irq)
  );

  function automatic logic [7:0] ctl(bit run, logic [1:0] mode, bit oe, bit ie, bit uf);
    return {2'b00, uf, ie, oe, mode, run};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, return at the following negedge
  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, bit m, output logic [7:0] d);
    addr = a; rmw = m;
    #1 d = rdata;
    rmw = 1'b0;
  endtask

  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    while (pin == 1'b0 && lo < 2000) begin lo++; @(negedge clk); end
    while (pin == 1'b1 && hi < 2000) begin hi++; @(negedge clk); end
  endtask

  task automatic stop_clear();
    wr(3'd4, ctl(0, 2'b00, 0, 0, 0));
    wr(3'd4, ctl(0, 2'b00, 0, 0, 0));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    gpio = 1'b1;
    @(negedge clk);
    rd(3'd4, 0, d);  chk(d == 8'h00, "R1 ctrl reset", d, 0);
    rd(3'd2, 0, d);  chk(d == 8'h00, "R1 reload reset", d, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk(pin == 1'b1, "R1 pin follows gpio", pin, 1);
    gpio = 1'b0;
  endtask

  task automatic t_regs();
    logic [7:0] d;
    for (int k = 0; k < 4; k++) wr(3'(k), 8'(8'h5A + 8'(17 * k)));
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), 0, d);
      chk(d == 8'(8'h5A + 8'(17 * k)), "R2 readback", d, 8'h5A + 17 * k);
    end
  endtask

  task automatic t_dual();
    int lo, hi;
    logic [7:0] d;
    wr(3'd2, 8'd3); wr(3'd3, 8'd5);
    wr(3'd4, ctl(1, 2'b00, 1, 1, 0));
    measure(lo, hi);
    chk(lo == 4, "R3 dual low phase", lo, 4);
    chk(hi == 6, "R3 dual high phase", hi, 6);
    rd(3'd4, 0, d); chk(d[5] == 1'b1, "R7 flag after upper underflow", d[5], 1);
    chk(irq == 1'b1, "R11 irq with ie and flag", irq, 1);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    wr(3'd4, ctl(0, 2'b00, 1, 1, 1));
    rd(3'd4, 0, d); chk(d[5] == 1'b1, "R8 write 1 keeps flag", d[5], 1);
    wr(3'd4, ctl(0, 2'b00, 1, 1, 0));
    rd(3'd4, 0, d); chk(d[5] == 1'b0, "R8 write 0 clears flag", d[5], 0);
    chk(irq == 1'b0, "R11 irq drops with flag", irq, 0);
    wr(3'd4, ctl(0, 2'b00, 1, 1, 1));
    rd(3'd4, 0, d); chk(d[5] == 1'b0, "R8 write 1 does not set", d[5], 0);
    rd(3'd4, 1, d); chk(d[5] == 1'b1, "R10 rmw read returns 1", d[5], 1);
    rd(3'd4, 0, d); chk(d[5] == 1'b0, "R10 plain read true flag", d[5], 0);
    chk(pin == 1'b0, "R13 idle level low", pin, 0);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    wr(3'd2, 8'd0); wr(3'd3, 8'd0);
    wr(3'd4, ctl(1, 2'b00, 0, 0, 0));
    repeat (4) @(negedge clk);
    rd(3'd4, 0, d); chk(d[5] == 1'b1, "R7 flag set with ie off", d[5], 1);
    chk(irq == 1'b0, "R11 no irq with ie off", irq, 0);
    wr(3'd4, ctl(1, 2'b00, 0, 0, 0));
    rd(3'd4, 0, d); chk(d[5] == 1'b1, "R9 set beats clear", d[5], 1);
    stop_clear();
  endtask

  task automatic t_presc();
    int lo, hi;
    wr(3'd0, 8'd1); wr(3'd1, 8'd1);
    wr(3'd2, 8'd2); wr(3'd3, 8'd1);
    wr(3'd4, ctl(1, 2'b01, 1, 0, 0));
    measure(lo, hi);
    chk(lo == 6, "R4 prescaler low phase", lo, 6);
    chk(hi == 4, "R4 prescaler high phase", hi, 4);
    stop_clear();
  endtask

  task automatic t_casc();
    int lo, hi;
    logic [7:0] d;
    wr(3'd0, 8'h02); wr(3'd2, 8'h01);
    wr(3'd1, 8'h03); wr(3'd3, 8'h00);
    wr(3'd4, ctl(1, 2'b10, 1, 0, 0));
    rd(3'd4, 0, d);
    measure(lo, hi);
    chk(lo == 259, "R5 cascade low phase", lo, 259);
    chk(hi == 4, "R5 cascade high phase", hi, 4);
    rd(3'd4, 0, d); chk(d[5] == 1'b1, "R7 flag on 16-bit underflow", d[5], 1);
    stop_clear();
  endtask

  task automatic t_gate();
    int lo, hi;
    logic [7:0] d;
    wr(3'd2, 8'd2); wr(3'd3, 8'd1);
    @(negedge clk); cnt_en = 1'b0;
    wr(3'd4, ctl(1, 2'b00, 1, 0, 0));
    repeat (20) @(negedge clk);
    chk(pin == 1'b0, "R6 pin holds without tick", pin, 0);
    rd(3'd4, 0, d); chk(d[5] == 1'b0, "R6 flag holds without tick", d[5], 0);
    cnt_en = 1'b1;
    measure(lo, hi);
    chk(lo == 3, "R6 low phase after tick resumes", lo, 3);
    stop_clear();
  endtask

  task automatic t_oe_idle();
    int lo, hi;
    wr(3'd2, 8'd0); wr(3'd3, 8'd9);
    wr(3'd4, ctl(1, 2'b00, 0, 0, 0));
    gpio = 1'b1; #1 chk(pin == 1'b1, "R12 pin is gpio high", pin, 1);
    gpio = 1'b0; #1 chk(pin == 1'b0, "R12 pin is gpio low", pin, 0);
    stop_clear();
    wr(3'd4, ctl(1, 2'b00, 1, 0, 0));
    @(negedge clk);
    chk(pin == 1'b1, "R12 pin carries pulse", pin, 1);
    wr(3'd4, ctl(0, 2'b00, 1, 0, 0));
    @(negedge clk);
    chk(pin == 1'b0, "R13 stop forces level low", pin, 0);
    wr(3'd4, ctl(1, 2'b00, 1, 0, 0));
    measure(lo, hi);
    chk(lo == 1, "R13 restart from low reload", lo, 1);
    stop_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_regs();
        stop_clear();
        t_dual();
        t_flag();
        t_set_wins();
        t_presc();
        t_casc();
        t_gate();
        t_oe_idle();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog all actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule